// File: doc/BRIEF.md
# Memory-Stall Level Attribution Counters

This block measures how hard the execution core has to cope with memory latency. Each clock it looks at an "any micro-op ready to execute" flag and, for each of four memory levels, a "load pending from this level" flag and a "load missed this level" flag. A cycle with nothing ready to execute and at least one load outstanding is a memory-stall cycle. The block counts every such cycle in a total counter and charges it to at most one level counter: the level of the deepest outstanding load, provided no load has missed that level.

The counts record pressure on the core, not lost throughput. Every qualifying cycle is counted whether or not later stages caught up afterwards. The flag inputs are captured in a register stage before they are classified, so each counter moves two clock edges after the flags that caused the move.

The flags come from load tracking and cache logic outside the block. They are control inputs with no handshake. The counters are plain status outputs, sampled whenever the reader likes.

Top module: `msa_stall_attr`

## Requirements
- R1: In a cycle where `uop_ready_i` is 1, no counter changes, whatever the load flags show.
- R2: In a cycle where `uop_ready_i` is 0, `stall_cnt_o` increments if at least one bit of `ld_pend_i` is 1. It does not change if every bit of `ld_pend_i` is 0.
- R3: Level index 0 is the L1 group (both first-level data cache tiers together), index 1 is L2, index 2 is L3 and index 3 is DRAM, in both `ld_pend_i` and `ld_miss_i`. Counter i sits at bits `[i*CW +: CW]` of `lvl_cnt_o`. In a stall cycle only the counter of the highest-index pending level may increment, and never more than one level counter moves in a cycle.
- R4: If the highest-index pending level also has its `ld_miss_i` bit set, no level counter increments in that cycle, while `stall_cnt_o` still counts it. A miss bit at a level with no pending load has no effect.
- R5: The L3 counter increments only in stall cycles where L3 is pending, L3 is not missed and DRAM is not pending.
- R6: Flags presented before clock edge k first show in the counters after edge k+1, not after edge k.
- R7: Every counter saturates at 2^CW-1 and holds that value.
- R8: Asserting `rst_n` low clears all counters and the captured flags. After reset the captured flags read as "micro-op ready, nothing pending".
- R9: Consecutive stall cycles are each counted. There is no edge detection or merging.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| uop_ready_i | input | 1 | 1 when at least one micro-op is ready to execute this cycle |
| ld_pend_i | input | NLVL | Per level: a load is pending from that level |
| ld_miss_i | input | NLVL | Per level: a load has missed that level |
| lvl_cnt_o | output | NLVL*CW | Per-level stall cycle counters, level i at bits [i*CW +: CW] |
| stall_cnt_o | output | CW | Total memory-stall cycle counter |

## Verification
Flags driven before a rising edge are captured at that edge and counted at the next one. Every counter result is therefore due two edges after its stimulus. The bench drives each vector at a falling edge, replaces it with idle flags at the next falling edge, and compares all five counters at the falling edge after that. A directed test samples one edge after a stimulus to show that nothing has moved yet, and then samples again at the second edge. The checker's properties use a one-cycle delayed copy of the inputs, so the cause sits one edge before the `|=>` consequence.

// File: rtl/msa_pkg.sv
package msa_pkg;
  // Level indices used on every per-level vector
  localparam int unsigned LVL_L1GRP = 0;
  localparam int unsigned LVL_L2    = 1;
  localparam int unsigned LVL_L3    = 2;
  localparam int unsigned LVL_DRAM  = 3;
  localparam int unsigned NUM_LVL   = 4;

  typedef struct packed {
    logic                rdy;
    logic [NUM_LVL-1:0]  pend;
    logic [NUM_LVL-1:0]  miss;
  } flags_t;
endpackage

// File: rtl/msa_flag_stage.sv
module msa_flag_stage #(
  parameter int unsigned NLVL = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            rdy_d,
  input  logic [NLVL-1:0] pend_d,
  input  logic [NLVL-1:0] miss_d,
  output logic            rdy_q,
  output logic [NLVL-1:0] pend_q,
  output logic [NLVL-1:0] miss_q
);
  // Reset value means "core busy, nothing outstanding": no counting (R8)
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdy_q  <= 1'b1;
      pend_q <= '0;
      miss_q <= '0;
    end else begin
      rdy_q  <= rdy_d;
      pend_q <= pend_d;
      miss_q <= miss_d;
    end
  end
endmodule

// File: rtl/msa_classify.sv
module msa_classify #(
  parameter int unsigned NLVL = 4
) (
  input  logic            rdy,
  input  logic [NLVL-1:0] pend,
  input  logic [NLVL-1:0] miss,
  output logic [NLVL-1:0] credit,
  output logic            stall_hit
);
  // A stall candidate: nothing ready and something outstanding (R1, R2)
  assign stall_hit = !rdy && (|pend);

  // Walk from the deepest level upward; only the first pending level
  // seen may earn credit, and only if it was not missed (R3, R4, R5)
  always_comb begin
    logic deeper_pend;
    credit      = '0;
    deeper_pend = 1'b0;
    for (int i = NLVL - 1; i >= 0; i--) begin
      if (!rdy && pend[i] && !deeper_pend && !miss[i])
        credit[i] = 1'b1;
      if (pend[i])
        deeper_pend = 1'b1;
    end
  end
endmodule

// File: rtl/msa_sat_ctr.sv
module msa_sat_ctr #(
  parameter int unsigned CW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          inc,
  output logic [CW-1:0] count
);
  localparam logic [CW-1:0] TOP = {CW{1'b1}};

  // Saturating up-counter (R7)
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      count <= '0;
    else if (inc && count != TOP)
      count <= count + 1'b1;
  end
endmodule

// File: rtl/msa_stall_attr.sv
module msa_stall_attr #(
  parameter int unsigned NLVL = msa_pkg::NUM_LVL,
  parameter int unsigned CW   = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               uop_ready_i,
  input  logic [NLVL-1:0]    ld_pend_i,
  input  logic [NLVL-1:0]    ld_miss_i,
  output logic [NLVL*CW-1:0] lvl_cnt_o,
  output logic [CW-1:0]      stall_cnt_o
);
  logic            rdy_q;
  logic [NLVL-1:0] pend_q;
  logic [NLVL-1:0] miss_q;
  logic [NLVL-1:0] credit;
  logic            stall_hit;

  // Stage 1: capture the flags (R6)
  msa_flag_stage #(.NLVL(NLVL)) u_stage (
    .clk    (clk),
    .rst_n  (rst_n),
    .rdy_d  (uop_ready_i),
    .pend_d (ld_pend_i),
    .miss_d (ld_miss_i),
    .rdy_q  (rdy_q),
    .pend_q (pend_q),
    .miss_q (miss_q)
  );

  // Stage 2: classify the captured cycle
  msa_classify #(.NLVL(NLVL)) u_cls (
    .rdy       (rdy_q),
    .pend      (pend_q),
    .miss      (miss_q),
    .credit    (credit),
    .stall_hit (stall_hit)
  );

  // One counter per level (R9: one increment per qualifying cycle)
  for (genvar g = 0; g < NLVL; g++) begin : g_lvl
    msa_sat_ctr #(.CW(CW)) u_ctr (
      .clk   (clk),
      .rst_n (rst_n),
      .inc   (credit[g]),
      .count (lvl_cnt_o[g*CW +: CW])
    );
  end

  msa_sat_ctr #(.CW(CW)) u_tot (
    .clk   (clk),
    .rst_n (rst_n),
    .inc   (stall_hit),
    .count (stall_cnt_o)
  );
endmodule

// File: rtl/msa_stall_attr_chk.sv
module msa_stall_attr_chk #(
  parameter int unsigned NLVL = 4,
  parameter int unsigned CW   = 32
) (
  input logic               clk,
  input logic               rst_n,
  input logic               uop_ready_i,
  input logic [NLVL-1:0]    ld_pend_i,
  input logic [NLVL-1:0]    ld_miss_i,
  input logic [NLVL*CW-1:0] lvl_cnt_o,
  input logic [CW-1:0]      stall_cnt_o
);
  localparam logic [CW-1:0] TOP = {CW{1'b1}};

  // Checker-side delayed copy of the inputs and previous counter values
  logic               c_rdy;
  logic [NLVL-1:0]    c_pend;
  logic [NLVL-1:0]    c_miss;
  logic [NLVL*CW-1:0] c_prev;
  logic               c_armed;
  logic [NLVL-1:0]    c_chg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      c_rdy   <= 1'b1;
      c_pend  <= '0;
      c_miss  <= '0;
      c_prev  <= '0;
      c_armed <= 1'b0;
    end else begin
      c_rdy   <= uop_ready_i;
      c_pend  <= ld_pend_i;
      c_miss  <= ld_miss_i;
      c_prev  <= lvl_cnt_o;
      c_armed <= 1'b1;
    end
  end

  always_comb begin
    for (int i = 0; i < NLVL; i++)
      c_chg[i] = lvl_cnt_o[i*CW +: CW] != c_prev[i*CW +: CW];
  end

  a_r1_ready_freezes: assert property (@(posedge clk) disable iff (!rst_n)
    c_rdy |=> ($stable(stall_cnt_o) && $stable(lvl_cnt_o)));

  a_r2_idle_no_total: assert property (@(posedge clk) disable iff (!rst_n)
    (!c_rdy && c_pend == '0) |=> $stable(stall_cnt_o));

  a_r2_total_counts: assert property (@(posedge clk) disable iff (!rst_n)
    (!c_rdy && (|c_pend) && stall_cnt_o != TOP)
      |=> stall_cnt_o == CW'($past(stall_cnt_o) + 1'b1));

  a_r3_single_level: assert property (@(posedge clk) disable iff (!rst_n)
    c_armed |-> $countones(c_chg) <= 1);

  a_r4_deep_miss_no_credit: assert property (@(posedge clk) disable iff (!rst_n)
    (!c_rdy && c_pend[NLVL-1] && c_miss[NLVL-1]) |=> $stable(lvl_cnt_o));

  a_r5_deepest_blocks_shallower: assert property (@(posedge clk) disable iff (!rst_n)
    c_pend[NLVL-1] |=> $stable(lvl_cnt_o[(NLVL-1)*CW-1:0]));

  a_r7_total_holds_at_top: assert property (@(posedge clk) disable iff (!rst_n)
    (stall_cnt_o == TOP) |=> (stall_cnt_o == TOP));
endmodule

bind msa_stall_attr msa_stall_attr_chk #(.NLVL(NLVL), .CW(CW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .uop_ready_i (uop_ready_i),
  .ld_pend_i   (ld_pend_i),
  .ld_miss_i   (ld_miss_i),
  .lvl_cnt_o   (lvl_cnt_o),
  .stall_cnt_o (stall_cnt_o)
);

// File: tb/sim_msa_stall_attr.sv
module sim_msa_stall_attr;
  localparam int unsigned NLVL = 4;
  localparam int unsigned CW   = 6;
  localparam int unsigned TOPV = (1 << CW) - 1;
  localparam int unsigned NVEC = 12;

  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic               uop_ready_i = 1'b1;
  logic [NLVL-1:0]    ld_pend_i = '0;
  logic [NLVL-1:0]    ld_miss_i = '0;
  logic [NLVL*CW-1:0] lvl_cnt_o;
  logic [CW-1:0]      stall_cnt_o;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;
  int exp_lvl [NLVL];
  int exp_tot;

  always #2.5 clk = ~clk;

  msa_stall_attr #(.NLVL(NLVL), .CW(CW)) u0 (
    .clk         (clk),
    .rst_n       (rst_n),
    .uop_ready_i (uop_ready_i),
    .ld_pend_i   (ld_pend_i),
    .ld_miss_i   (ld_miss_i),
    .lvl_cnt_o   (lvl_cnt_o),
    .stall_cnt_o (stall_cnt_o)
  );

  // {ready, pend[3:0], miss[3:0], charged level (4 = none), total step}
  localparam logic [12:0] VEC [NVEC] = '{
    {1'b1, 4'b1111, 4'b0000, 3'd4, 1'b0},  // R1 ready suppresses all
    {1'b0, 4'b0000, 4'b0000, 3'd4, 1'b0},  // R2 nothing pending
    {1'b0, 4'b0001, 4'b0000, 3'd0, 1'b1},  // R3 L1 group only
    {1'b0, 4'b0011, 4'b0000, 3'd1, 1'b1},  // R3 L2 deepest
    {1'b0, 4'b0111, 4'b0000, 3'd2, 1'b1},  // R5 L3 without DRAM
    {1'b0, 4'b1111, 4'b0000, 3'd3, 1'b1},  // R3 DRAM deepest
    {1'b0, 4'b0100, 4'b0100, 3'd4, 1'b1},  // R4 L3 missed
    {1'b0, 4'b1100, 4'b1000, 3'd4, 1'b1},  // R5 DRAM pending blocks L3
    {1'b0, 4'b0011, 4'b0010, 3'd4, 1'b1},  // R4 L2 missed
    {1'b0, 4'b0001, 4'b0010, 3'd0, 1'b1},  // R4 stray miss ignored
    {1'b0, 4'b0101, 4'b0001, 3'd2, 1'b1},  // R3 shallow miss irrelevant
    {1'b1, 4'b0001, 4'b0000, 3'd4, 1'b0}   // R1 ready again
  };

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic check_all(input string req);
    for (int i = 0; i < NLVL; i++)
      check(req, int'(lvl_cnt_o[i*CW +: CW]), exp_lvl[i]);
    check(req, int'(stall_cnt_o), exp_tot);
  endtask

  task automatic go_idle();
    uop_ready_i = 1'b1;
    ld_pend_i   = '0;
    ld_miss_i   = '0;
  endtask

  function automatic int sat(input int v);
    return (v > int'(TOPV)) ? int'(TOPV) : v;
  endfunction

  initial begin
    for (int i = 0; i < NLVL; i++) exp_lvl[i] = 0;
    exp_tot = 0;
    repeat (3) @(negedge clk);
    check_all("R8 reset state");
    rst_n = 1'b1;
    @(negedge clk);

    // Vector table walk: drive, go idle, compare two edges after drive
    for (int v = 0; v < NVEC; v++) begin
      uop_ready_i = VEC[v][12];
      ld_pend_i   = VEC[v][11:8];
      ld_miss_i   = VEC[v][7:4];
      @(negedge clk);
      go_idle();
      @(negedge clk);
      if (VEC[v][3:1] < 3'd4) exp_lvl[VEC[v][3:1]]++;
      if (VEC[v][0]) exp_tot++;
      check_all($sformatf("R3 vector %0d", v));
    end

    // R6: nothing one edge after the stimulus, result after the second
    uop_ready_i = 1'b0; ld_pend_i = 4'b0011; ld_miss_i = '0;
    @(negedge clk);
    go_idle();
    check("R6 not yet counted", int'(stall_cnt_o), exp_tot);
    @(negedge clk);
    exp_lvl[1]++; exp_tot++;
    check("R6 counted after second edge", int'(stall_cnt_o), exp_tot);
    check("R6 L2 counted", int'(lvl_cnt_o[1*CW +: CW]), exp_lvl[1]);

    // R9: five back-to-back DRAM stall cycles
    uop_ready_i = 1'b0; ld_pend_i = 4'b1000; ld_miss_i = '0;
    repeat (5) @(negedge clk);
    go_idle();
    @(negedge clk);
    exp_lvl[3] += 5; exp_tot += 5;
    check_all("R9 consecutive stalls");

    // R7: long L1-group stall drives L1 and total to saturation
    uop_ready_i = 1'b0; ld_pend_i = 4'b0001; ld_miss_i = '0;
    repeat (70) @(negedge clk);
    go_idle();
    @(negedge clk);
    exp_lvl[0] = sat(exp_lvl[0] + 70);
    exp_tot    = sat(exp_tot + 70);
    check_all("R7 saturation");
    check("R7 total at top", int'(stall_cnt_o), int'(TOPV));

    // R8: reset in the middle of a stall clears everything
    uop_ready_i = 1'b0; ld_pend_i = 4'b0100; ld_miss_i = '0;
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    go_idle();
    for (int i = 0; i < NLVL; i++) exp_lvl[i] = 0;
    exp_tot = 0;
    check_all("R8 mid-run reset");
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check_all("R8 captured flags cleared");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule